// File: doc/BRIEF.md
# Data Watchpoint Match Unit

This unit watches the data accesses of a processor pipeline and reports a debug event when an access lands on a watched byte. Each of several slots holds a watch address register and a control register. The watch address register holds a word-aligned base. The control register holds an enable bit, a privilege filter, an access-kind filter and an 8-bit mask of watched bytes. The mask covers an aligned 8-byte window that starts at the base.

Each cycle the pipeline can present one access. An access is described by its byte address, a size code, its kind (load, store or swap) and a privileged flag. The unit works out every byte the access touches. A slot hits when any touched byte is marked in that slot's mask and the kind and privilege filters both accept the access. The size of the access and its alignment do not matter. One cycle later the unit raises a single-cycle event that carries the lowest-numbered slot that hit.

Top module: `dwatch_unit`

## Requirements
- R1: A write with `cfg_ctrl`=0 stores the address into the slot's watch base and drops address bits [1:0], so the window always starts on a word boundary.
- R2: Mask bit j of the control word (bit 5+j, with j from 0 to 7) watches the byte at base+j. A one-byte access hits only when the mask bit for its byte is set.
- R3: An access hits if it touches any watched byte. This holds when the access is larger than the watched region and when it is smaller.
- R4: An unaligned access that starts in the word before the window still hits when its bytes spill into a watched byte.
- R5: An access whose bytes all fall outside the 8-byte window never hits.
- R6: Control bits [4:3] filter by kind. The access kind `acc_kind` uses bit 0 for read and bit 1 for write: 01 is a load, 10 is a store, 11 is a swap and 00 is no data access. The filter value 01 accepts loads and swaps, 10 accepts stores and swaps, 11 accepts all three, and 00 accepts nothing. Kind 00 never hits.
- R7: Control bits [2:1] filter by privilege. The value 01 accepts privileged accesses only, 10 accepts unprivileged accesses only, 11 accepts both, and 00 accepts neither.
- R8: A slot whose control bit 0 is clear never produces an event, whatever its other fields hold.
- R9: `evt_pulse` is high for exactly the cycle after a valid access that hit. It stays low after an idle cycle or a miss, and `evt_slot` reads 0 whenever `evt_pulse` is low.
- R10: When several slots hit, `evt_slot` gives the lowest index among them.
- R11: `acc_size` codes 0, 1, 2 and 3 select access lengths of 1, 2, 4 and 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all slots |
| cfg_we | input | 1 | Register write strobe |
| cfg_ctrl | input | 1 | 1 selects the control register, 0 selects the watch address |
| cfg_slot | input | SW | Slot written |
| cfg_wdata | input | AW | Write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | AW | Byte address of the access |
| acc_size | input | 2 | Log2 of the access length in bytes |
| acc_kind | input | 2 | Bit 0 is read, bit 1 is write |
| acc_priv | input | 1 | The access is privileged |
| evt_pulse | output | 1 | Registered one-cycle debug event |
| evt_slot | output | SW | Lowest slot index that hit |

## Verification
The hardest case to reach is an access that is not aligned and crosses into the window from the word below the base while only a high or low mask bit is set. Purely random addresses rarely land there. The stimulus therefore draws addresses from a narrow band around each slot's base, from 8 bytes below it to 12 bytes above, and adds directed accesses that straddle both edges of the window with every size. Overlapping slots with different filters are also set up on purpose, so that the lowest-index choice is exercised against slots that are rejected for kind or privilege.

// File: rtl/dwatch_unit.sv
module dwatch_unit #(
  parameter int NSLOT = 4,
  parameter int AW    = 32,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_ctrl,
  input  logic [SW-1:0] cfg_slot,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic [1:0]    acc_kind,
  input  logic          acc_priv,
  output logic          evt_pulse,
  output logic [SW-1:0] evt_slot
);
  logic [AW-1:2] wbase [NSLOT];
  logic [12:0]   wctl  [NSLOT];
  logic [NSLOT-1:0] hit, en_vec;
  logic [AW-1:0] len;
  logic [SW-1:0] sel;

  assign len = {{(AW-4){1'b0}}, 4'b0001} << acc_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        wbase[i] <= '0;
        wctl[i]  <= '0;
      end
    end else if (cfg_we && int'(cfg_slot) < NSLOT) begin
      if (cfg_ctrl) wctl[cfg_slot]  <= cfg_wdata[12:0];
      else          wbase[cfg_slot] <= cfg_wdata[AW-1:2];
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [AW-1:0] base;
    logic [7:0]    touch;
    logic          kind_ok, priv_ok;
    assign base    = {wbase[g], 2'b00};
    assign kind_ok = |(wctl[g][4:3] & acc_kind);
    assign priv_ok = acc_priv ? wctl[g][1] : wctl[g][2];
    assign en_vec[g] = wctl[g][0];
    always_comb
      for (int j = 0; j < 8; j++)
        touch[j] = ((base + AW'(j)) - acc_addr) < len;
    assign hit[g] = acc_valid & wctl[g][0] & kind_ok & priv_ok &
                    |(touch & wctl[g][12:5]);
  end

  always_comb begin
    sel = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (hit[i]) sel = SW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_pulse <= 1'b0;
      evt_slot  <= '0;
    end else begin
      evt_pulse <= |hit;
      evt_slot  <= (|hit) ? sel : '0;
    end
  end
endmodule

module dwatch_unit_chk #(
  parameter int NSLOT = 4,
  parameter int SW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic [NSLOT-1:0] hit,
  input logic [NSLOT-1:0] en_vec,
  input logic             evt_pulse,
  input logic [SW-1:0]    evt_slot
);
  logic [NSLOT-1:0] hit_prev, en_prev, below;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hit_prev <= '0;
      en_prev  <= '0;
    end else begin
      hit_prev <= hit;
      en_prev  <= en_vec;
    end
  assign below = (NSLOT'(1) << evt_slot) - NSLOT'(1);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !evt_pulse);
  // R9
  slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_pulse |-> evt_slot == '0);
  // R8
  enabled_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> (int'(evt_slot) < NSLOT) && en_prev[evt_slot]);
  // R10
  lowest_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> hit_prev[evt_slot] && ((hit_prev & below) == '0));
  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> $past(acc_valid));
endmodule

bind dwatch_unit dwatch_unit_chk #(.NSLOT(NSLOT), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .hit(hit),
  .en_vec(en_vec), .evt_pulse(evt_pulse), .evt_slot(evt_slot));

// File: tb/sim_dwatch_unit.sv
module sim_dwatch_unit;
  localparam int NS = 4;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_ctrl = 0;
  logic [1:0] cfg_slot = 0;
  logic [AW-1:0] cfg_wdata = 0;
  logic acc_valid = 0, acc_priv = 0;
  logic [AW-1:0] acc_addr = 0;
  logic [1:0] acc_size = 0, acc_kind = 0;
  logic evt_pulse;
  logic [1:0] evt_slot;
  int total = 0, bad = 0;
  logic [AW-1:0] m_base [NS];
  logic [12:0]   m_ctl  [NS];

  always #4 clk = ~clk;

  dwatch_unit #(.NSLOT(NS), .AW(AW)) u0 (.*);

  function automatic logic [12:0] mk(bit en, bit [1:0] pv, bit [1:0] ls, bit [7:0] bs);
    return {bs, ls, pv, en};
  endfunction

  function automatic int model(logic [AW-1:0] a, int sz, logic [1:0] k, logic p);
    for (int s = 0; s < NS; s++) begin
      logic [12:0] c = m_ctl[s];
      bit any = 0;
      for (int b = 0; b < (1 << sz); b++) begin
        logic [AW-1:0] d = a + AW'(b) - m_base[s];
        if (d < 8 && c[5 + d[2:0]]) any = 1;
      end
      if (c[0] && any && ((c[3] && k[0]) || (c[4] && k[1])) && (p ? c[1] : c[2]))
        return s;
    end
    return -1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int s, bit c, logic [AW-1:0] d);
    cfg_we = 1; cfg_ctrl = c; cfg_slot = 2'(s); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
    if (c) m_ctl[s] = d[12:0]; else m_base[s] = {d[AW-1:2], 2'b00};
  endtask

  task automatic acc(string req, logic [AW-1:0] a, int sz, logic [1:0] k, logic p, int exp);
    acc_valid = 1; acc_addr = a; acc_size = 2'(sz); acc_kind = k; acc_priv = p;
    @(posedge clk); #1;
    acc_valid = 0;
    chk(req, {31'd0, evt_pulse}, {31'd0, exp >= 0});
    chk(req, {30'd0, evt_slot}, exp >= 0 ? exp : 0);
    if (model(a, sz, k, p) != exp) begin
      total++; bad++;
      $display("FAIL %s model=%0d expected=%0d", req, model(a, sz, k, p), exp);
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin m_base[s] = 0; m_ctl[s] = 0; end
    #20; rst_n = 1; #3;
    chk("reset R9", {31'd0, evt_pulse}, 0);
    chk("reset R9", {30'd0, evt_slot}, 0);

    wr(0, 0, 32'h103); wr(0, 1, 32'(mk(1, 3, 3, 8'h01)));
    acc("R1", 32'h100, 0, 2'b01, 1, 0);
    acc("R2", 32'h101, 0, 2'b01, 1, -1);
    wr(0, 1, 32'(mk(1, 3, 3, 8'h80)));
    acc("R2", 32'h107, 0, 2'b01, 1, 0);
    acc("R2", 32'h106, 0, 2'b01, 1, -1);
    wr(0, 1, 32'(mk(1, 3, 3, 8'h0C)));
    acc("R3", 32'h100, 3, 2'b10, 0, 0);
    acc("R3", 32'h103, 0, 2'b10, 0, 0);
    wr(0, 1, 32'(mk(1, 3, 3, 8'h01)));
    acc("R4", 32'h0FE, 2, 2'b01, 1, 0);
    acc("R4", 32'h0F9, 3, 2'b01, 1, 0);
    wr(0, 1, 32'(mk(1, 3, 3, 8'hFF)));
    acc("R5", 32'h0FC, 2, 2'b01, 1, -1);
    acc("R5", 32'h108, 3, 2'b01, 1, -1);
    acc("R5", 32'h0F8, 3, 2'b01, 1, -1);
    for (int l = 0; l < 4; l++) begin
      wr(0, 1, 32'(mk(1, 3, 2'(l), 8'hFF)));
      for (int k = 0; k < 4; k++)
        acc("R6", 32'h102, 0, 2'(k), 1, ((l & k) != 0) ? 0 : -1);
    end
    for (int v = 0; v < 4; v++) begin
      wr(0, 1, 32'(mk(1, 2'(v), 3, 8'hFF)));
      acc("R7", 32'h100, 1, 2'b01, 1, v[0] ? 0 : -1);
      acc("R7", 32'h100, 1, 2'b01, 0, v[1] ? 0 : -1);
    end
    wr(0, 1, 32'(mk(0, 3, 3, 8'hFF)));
    acc("R8", 32'h100, 3, 2'b11, 1, -1);
    acc("R8", 32'h104, 2, 2'b01, 0, -1);
    wr(0, 1, 32'(mk(1, 3, 3, 8'h10)));
    acc("R11", 32'h103, 0, 2'b01, 1, -1);
    acc("R11", 32'h103, 1, 2'b01, 1, 0);
    acc("R11", 32'h101, 1, 2'b01, 1, -1);
    acc("R11", 32'h101, 2, 2'b01, 1, 0);
    acc("R11", 32'h0FD, 2, 2'b01, 1, -1);
    acc("R11", 32'h0FD, 3, 2'b01, 1, 0);
    // R9: idle cycle after a hit and a valid-low access drop the pulse
    acc("R9", 32'h104, 0, 2'b01, 1, 0);
    acc_addr = 32'h104; acc_valid = 0;
    @(posedge clk); #1;
    chk("R9", {31'd0, evt_pulse}, 0);
    wr(0, 1, 32'(mk(1, 1, 3, 8'hFF)));
    wr(1, 0, 32'h200); wr(1, 1, 32'(mk(1, 3, 1, 8'hFF)));
    wr(2, 0, 32'h200); wr(2, 1, 32'(mk(1, 3, 3, 8'hFF)));
    wr(3, 0, 32'h204); wr(3, 1, 32'(mk(1, 3, 3, 8'hF0)));
    acc("R10", 32'h204, 0, 2'b01, 0, 1);
    acc("R10", 32'h204, 0, 2'b10, 0, 2);
    acc("R10", 32'h208, 0, 2'b10, 0, 3);

    for (int n = 0; n < 3000; n++) begin
      if (n % 200 == 0)
        for (int s = 0; s < NS; s++) begin
          logic [AW-1:0] b = 32'h1000 + ($urandom % 64) * 4 + ($urandom % 4);
          wr(s, 0, b);
          wr(s, 1, 32'(mk(($urandom % 8) != 0, 2'($urandom), 2'($urandom), 8'($urandom))));
        end
      begin
        int s = $urandom % NS;
        logic [AW-1:0] a = m_base[s] - 8 + ($urandom % 21);
        int sz = $urandom % 4;
        logic [1:0] k = 2'($urandom);
        logic p = 1'($urandom);
        acc("R3 R4 R5 R6 R7 R10 rand", a, sz, k, p, model(a, sz, k, p));
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial void'($urandom(32'd1207));
endmodule